// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the programmable register file of a colour LCD controller. A host reaches it through a simple 32-bit, word-addressed read/write bus that covers a 4 KB window. It stores four panel timing words, the frame base addresses of the upper and lower panel halves, a control word and an interrupt mask. It also keeps a raw interrupt status that incoming event pulses set and that the host clears by writing ones.

From the stored words it drives the settings the rest of the controller uses: the active line width in pixels, the active line count, the pixel depth, the colour and ordering flags, and a display-enable qualifier. The upper eight words of the window return a fixed identification sequence. A strap input selects a board layout in which the control and interrupt-mask registers swap word locations.

Read data is combinational, so it is valid in the cycle the read is presented. Writes take effect at the clock edge that samples them.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset every register reads zero, the active width is 16, the active line count is 1, and `irq`, `bus_err` and `display_on` are low.
- R2: Word offsets map as follows: 0 to 3 are timing words 0 to 3, 4 is the upper base, 5 is the lower base, 6 is the interrupt mask, 7 is control, 8 is raw status, 9 is masked status, 10 is interrupt clear, 11 and 12 are current upper and lower address. Timing words and both bases read back exactly what was last written, and the bases also appear on `upper_base` and `lower_base`.
- R3: A write to timing word 0 with value v sets `active_cols` to ((v AND 0xFC) + 4) * 4.
- R4: A write to timing word 1 with value v sets `active_rows` to (v AND 0x3FF) + 1.
- R5: Control bits are decoded as follows: bits 3:1 form `depth_code`, bit 8 drives `bgr_order`, bit 9 drives `byte_big_endian` and bit 10 drives `pixel_big_endian`.
- R6: `bits_per_pixel` is 2 to the power of `depth_code` for codes 0 to 5 (1, 2, 4, 8, 16, 32) and 0 for codes 6 and 7.
- R7: `display_on` is high only when control bit 0 (enable) and control bit 11 (power) are both 1.
- R8: With `alt_layout` high, word offset 6 accesses control and word offset 7 accesses the interrupt mask. With `alt_layout` low the mapping of R2 applies.
- R9: Each `irq_src` pulse bit sets the matching raw status bit. Writing offset 10 clears every raw bit whose written bit is 1, and a set in the same cycle wins over the clear. Masked status reads raw AND mask. Offset 10 reads zero, and writes to offsets 8, 9, 11 and 12 change nothing.
- R10: `irq` is the OR of the masked status bits, registered: it changes one clock after the raw status or mask changes.
- R11: Offsets 11 and 12 read the programmed upper and lower base addresses.
- R12: Byte offsets 0xFE0 to 0xFFC read 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order, one byte per word in bits 7:0.
- R13: An access to an unmapped word (13 up to 0x3F7) or to an address whose bits 1:0 are not zero reads zero and ignores any write. It also raises `bus_err` for exactly one cycle, in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alt_layout | input | 1 | Strap: swap control and mask locations |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| irq_src | input | IRQ_W | Interrupt event pulses |
| irq | output | 1 | Registered OR of masked status |
| active_cols | output | 11 | Active pixels per line |
| active_rows | output | 11 | Active lines per frame |
| display_on | output | 1 | Enable and power both set |
| depth_code | output | 3 | Pixel depth code |
| bits_per_pixel | output | 6 | Decoded pixel width, 0 if invalid |
| bgr_order | output | 1 | Blue/red swap |
| byte_big_endian | output | 1 | Big-endian byte order |
| pixel_big_endian | output | 1 | Big-endian pixel order in a byte |
| upper_base | output | 32 | Upper panel frame base |
| lower_base | output | 32 | Lower panel frame base |

## Verification
On every cycle the assertions check the geometry that follows a timing-0 or timing-1 write, the one-hot pixel-width decode, and the one-cycle lag of `irq` behind the masked status. They also check that a write-one clear leaves the targeted bits low and that unmapped accesses read zero and produce exactly one error pulse. The bench's scenarios are needed for the rest. These are the full arithmetic sweeps of both geometry fields, the layout swap under the strap, and the set-over-clear collision. The identification sequence and the proof that ignored writes left every register intact can also only be shown there.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int WORD_W  = ADDR_W - 2;
    localparam int DIM_W   = 11;
    localparam int DEPTH_W = 3;
    localparam int BPP_W   = 6;
    localparam logic [WORD_W-1:0] ID_WORD = WORD_W'(10'h3F8);

    // control bit positions
    localparam int CB_EN    = 0;
    localparam int CB_DEPTH = 1;
    localparam int CB_BGR   = 8;
    localparam int CB_BBYTE = 9;
    localparam int CB_BPIX  = 10;
    localparam int CB_PWR   = 11;

    typedef enum logic [3:0] {
        T_TIM0, T_TIM1, T_TIM2, T_TIM3,
        T_UBASE, T_LBASE, T_MASK, T_CTRL,
        T_RAW, T_MIS, T_ICLR, T_UCUR, T_LCUR,
        T_ID, T_NONE
    } tgt_e;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h10;
            3'd1:    id_byte = 8'h11;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
    import lcdc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              alt,
    output tgt_e              tgt,
    output logic [2:0]        id_idx
);
    logic [WORD_W-1:0] word;

    assign word   = addr[ADDR_W-1:2];
    assign id_idx = word[2:0];

    always_comb begin
        tgt = T_NONE;
        if (addr[1:0] == 2'b00) begin
            if (word >= ID_WORD) begin
                tgt = T_ID;
            end else begin
                case (word)
                    10'd0:   tgt = T_TIM0;
                    10'd1:   tgt = T_TIM1;
                    10'd2:   tgt = T_TIM2;
                    10'd3:   tgt = T_TIM3;
                    10'd4:   tgt = T_UBASE;
                    10'd5:   tgt = T_LBASE;
                    10'd6:   tgt = alt ? T_CTRL : T_MASK;
                    10'd7:   tgt = alt ? T_MASK : T_CTRL;
                    10'd8:   tgt = T_RAW;
                    10'd9:   tgt = T_MIS;
                    10'd10:  tgt = T_ICLR;
                    10'd11:  tgt = T_UCUR;
                    10'd12:  tgt = T_LCUR;
                    default: tgt = T_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
    import lcdc_pkg::*;
(
    input  logic [5:0]       col_field,
    input  logic [9:0]       row_field,
    output logic [DIM_W-1:0] cols,
    output logic [DIM_W-1:0] rows
);
    localparam int COL_SHIFT = 4;

    // ((v & 0xFC) + 4) * 4 == (v[7:2] + 1) * 16
    assign cols = (DIM_W'(col_field) + DIM_W'(1)) << COL_SHIFT;
    assign rows = DIM_W'(row_field) + DIM_W'(1);
endmodule

// File: rtl/lcdc_mode.sv
module lcdc_mode
    import lcdc_pkg::*;
(
    input  logic               en,
    input  logic               pwr,
    input  logic [DEPTH_W-1:0] depth,
    input  logic               bgr,
    input  logic               bbyte,
    input  logic               bpix,
    output logic               display_on,
    output logic [DEPTH_W-1:0] depth_code,
    output logic [BPP_W-1:0]   bits_per_pixel,
    output logic               bgr_order,
    output logic               byte_big_endian,
    output logic               pixel_big_endian
);
    assign display_on       = en & pwr;
    assign depth_code       = depth;
    assign bgr_order        = bgr;
    assign byte_big_endian  = bbyte;
    assign pixel_big_endian = bpix;

    for (genvar k = 0; k < BPP_W; k++) begin : g_bpp
        assign bits_per_pixel[k] = (depth == DEPTH_W'(k));
    end
endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
    import lcdc_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alt_layout,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    input  logic [IRQ_W-1:0]   irq_src,
    output logic               irq,
    output logic [DIM_W-1:0]   active_cols,
    output logic [DIM_W-1:0]   active_rows,
    output logic               display_on,
    output logic [DEPTH_W-1:0] depth_code,
    output logic [BPP_W-1:0]   bits_per_pixel,
    output logic               bgr_order,
    output logic               byte_big_endian,
    output logic               pixel_big_endian,
    output logic [DATA_W-1:0]  upper_base,
    output logic [DATA_W-1:0]  lower_base
);
    localparam int N_TIM = 4;

    typedef struct packed {
        logic [N_TIM-1:0][DATA_W-1:0] tim;
        logic [DATA_W-1:0]            ubase;
        logic [DATA_W-1:0]            lbase;
        logic [DATA_W-1:0]            ctrl;
        logic [IRQ_W-1:0]             mask;
        logic [IRQ_W-1:0]             raw;
        logic                         irq;
        logic                         err;
    } state_t;

    state_t st_d, st_q;
    tgt_e   tgt;
    logic [2:0]       id_idx;
    logic [IRQ_W-1:0] clr_bits;
    logic [IRQ_W-1:0] raw_now;
    logic [IRQ_W-1:0] mask_now;

    lcdc_addr_dec u_dec (
        .addr   (bus_addr),
        .alt    (alt_layout),
        .tgt    (tgt),
        .id_idx (id_idx)
    );

    // next-state computation
    always_comb begin
        st_d     = st_q;
        clr_bits = '0;
        if (bus_sel && bus_wr) begin
            case (tgt)
                T_TIM0:  st_d.tim[0] = bus_wdata;
                T_TIM1:  st_d.tim[1] = bus_wdata;
                T_TIM2:  st_d.tim[2] = bus_wdata;
                T_TIM3:  st_d.tim[3] = bus_wdata;
                T_UBASE: st_d.ubase  = bus_wdata;
                T_LBASE: st_d.lbase  = bus_wdata;
                T_MASK:  st_d.mask   = bus_wdata[IRQ_W-1:0];
                T_CTRL:  st_d.ctrl   = bus_wdata;
                T_ICLR:  clr_bits    = bus_wdata[IRQ_W-1:0];
                default: ;
            endcase
        end
        // new events win over a simultaneous clear
        st_d.raw = (st_q.raw & ~clr_bits) | irq_src;
        st_d.irq = |(st_q.raw & st_q.mask);
        st_d.err = bus_sel && (tgt == T_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (tgt)
                T_TIM0:  bus_rdata = st_q.tim[0];
                T_TIM1:  bus_rdata = st_q.tim[1];
                T_TIM2:  bus_rdata = st_q.tim[2];
                T_TIM3:  bus_rdata = st_q.tim[3];
                T_UBASE: bus_rdata = st_q.ubase;
                T_LBASE: bus_rdata = st_q.lbase;
                T_MASK:  bus_rdata = DATA_W'(st_q.mask);
                T_CTRL:  bus_rdata = st_q.ctrl;
                T_RAW:   bus_rdata = DATA_W'(st_q.raw);
                T_MIS:   bus_rdata = DATA_W'(st_q.raw & st_q.mask);
                T_UCUR:  bus_rdata = st_q.ubase;
                T_LCUR:  bus_rdata = st_q.lbase;
                T_ID:    bus_rdata = DATA_W'(id_byte(id_idx));
                default: bus_rdata = '0;
            endcase
        end
    end

    lcdc_geom u_geom (
        .col_field (st_q.tim[0][7:2]),
        .row_field (st_q.tim[1][9:0]),
        .cols      (active_cols),
        .rows      (active_rows)
    );

    lcdc_mode u_mode (
        .en               (st_q.ctrl[CB_EN]),
        .pwr              (st_q.ctrl[CB_PWR]),
        .depth            (st_q.ctrl[CB_DEPTH +: DEPTH_W]),
        .bgr              (st_q.ctrl[CB_BGR]),
        .bbyte            (st_q.ctrl[CB_BBYTE]),
        .bpix             (st_q.ctrl[CB_BPIX]),
        .display_on       (display_on),
        .depth_code       (depth_code),
        .bits_per_pixel   (bits_per_pixel),
        .bgr_order        (bgr_order),
        .byte_big_endian  (byte_big_endian),
        .pixel_big_endian (pixel_big_endian)
    );

    assign irq        = st_q.irq;
    assign bus_err    = st_q.err;
    assign upper_base = st_q.ubase;
    assign lower_base = st_q.lbase;
    assign raw_now    = st_q.raw;
    assign mask_now   = st_q.mask;
endmodule

// File: rtl/lcdc_regbank_chk.sv
module lcdc_regbank_chk
    import lcdc_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               bus_err,
    input logic [IRQ_W-1:0]   irq_src,
    input logic               irq,
    input logic [DIM_W-1:0]   active_cols,
    input logic [DIM_W-1:0]   active_rows,
    input logic [BPP_W-1:0]   bits_per_pixel,
    input logic [IRQ_W-1:0]   raw_now,
    input logic [IRQ_W-1:0]   mask_now
);
    logic [WORD_W-1:0] w;
    logic              unmapped;
    logic              wr_t0, wr_t1, wr_clr;

    assign w        = bus_addr[ADDR_W-1:2];
    assign unmapped = bus_sel && ((bus_addr[1:0] != 2'b00) ||
                      ((w > 10'd12) && (w < ID_WORD)));
    assign wr_t0    = bus_sel && bus_wr && (bus_addr == '0);
    assign wr_t1    = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));
    assign wr_clr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(40));

    a_r3_cols_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_t0 |=> active_cols == ((DIM_W'($past(bus_wdata[7:2])) + DIM_W'(1)) << 4));

    a_r4_rows_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_t1 |=> active_rows == (DIM_W'($past(bus_wdata[9:0])) + DIM_W'(1)));

    a_r6_bpp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bits_per_pixel));

    a_r10_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(raw_now & mask_now)));

    a_r9_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && irq_src == '0) |=> (raw_now & $past(bus_wdata[IRQ_W-1:0])) == '0);

    a_r13_err_after: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |=> bus_err);

    a_r13_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));

    a_r13_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (unmapped && !bus_wr) |-> bus_rdata == '0);
endmodule

bind lcdc_regbank lcdc_regbank_chk #(.IRQ_W(IRQ_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .bus_err        (bus_err),
    .irq_src        (irq_src),
    .irq            (irq),
    .active_cols    (active_cols),
    .active_rows    (active_rows),
    .bits_per_pixel (bits_per_pixel),
    .raw_now        (raw_now),
    .mask_now       (mask_now)
);

// File: tb/lcdc_regbank_test.sv
module lcdc_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_layout = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  irq_src = '0;
    logic        irq;
    logic [10:0] active_cols, active_rows;
    logic        display_on;
    logic [2:0]  depth_code;
    logic [5:0]  bits_per_pixel;
    logic        bgr_order, byte_big_endian, pixel_big_endian;
    logic [31:0] upper_base, lower_base;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] d;

    always #10 clk = ~clk;

    lcdc_regbank uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] s);
        @(negedge clk);
        irq_src = s;
        @(negedge clk);
        irq_src = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 cols", 32'(active_cols), 32'd16);
        chk("R1 rows", 32'(active_rows), 32'd1);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 err", 32'(bus_err), 32'd0);
        chk("R1 display_on", 32'(display_on), 32'd0);
        for (int k = 0; k < 13; k++) begin
            rd(12'(k * 4), d);
            chk("R1 reg zero", d, 32'd0);
        end

        // R2 storage and R11 current address
        for (int k = 0; k < 4; k++) begin
            wr(12'(k * 4), 32'hA5000000 + 32'(k * 32'h01010101));
        end
        wr(12'h010, 32'h8000_1000);
        wr(12'h014, 32'h0004_2000);
        for (int k = 0; k < 4; k++) begin
            rd(12'(k * 4), d);
            chk("R2 timing readback", d, 32'hA5000000 + 32'(k * 32'h01010101));
        end
        rd(12'h010, d); chk("R2 upper base", d, 32'h8000_1000);
        rd(12'h014, d); chk("R2 lower base", d, 32'h0004_2000);
        chk("R2 upper port", upper_base, 32'h8000_1000);
        chk("R2 lower port", lower_base, 32'h0004_2000);
        rd(12'h02C, d); chk("R11 upper current", d, 32'h8000_1000);
        rd(12'h030, d); chk("R11 lower current", d, 32'h0004_2000);

        // R3 full sweep of the low byte
        for (int v = 0; v < 256; v++) begin
            wr(12'h000, 32'h5A5A_0000 | 32'(v));
            chk("R3 cols", 32'(active_cols), ((32'(v) & 32'hFC) + 32'd4) * 32'd4);
        end
        // R4 full sweep of the row field
        for (int v = 0; v < 1024; v++) begin
            wr(12'h004, 32'hDEAD_0000 | 32'(v) | ((32'(v) & 32'h3F) << 10));
            chk("R4 rows", 32'(active_rows), (32'(v) & 32'h3FF) + 32'd1);
        end

        // R5 / R6 depth codes
        for (int c = 0; c < 8; c++) begin
            wr(12'h01C, 32'(c) << 1);
            chk("R5 depth_code", 32'(depth_code), 32'(c));
            chk("R6 bits_per_pixel", 32'(bits_per_pixel), (c < 6) ? (32'd1 << c) : 32'd0);
        end
        // R5 ordering flags
        for (int f = 0; f < 8; f++) begin
            wr(12'h01C, 32'(f) << 8);
            chk("R5 bgr", 32'(bgr_order), 32'(f & 1));
            chk("R5 byte order", 32'(byte_big_endian), 32'((f >> 1) & 1));
            chk("R5 pixel order", 32'(pixel_big_endian), 32'((f >> 2) & 1));
        end
        // R7 enable qualifier
        for (int e = 0; e < 4; e++) begin
            wr(12'h01C, ((e & 1) != 0 ? 32'h001 : 32'h0) | ((e & 2) != 0 ? 32'h800 : 32'h0));
            chk("R7 display_on", 32'(display_on), (e == 3) ? 32'd1 : 32'd0);
        end

        // R8 layout strap
        wr(12'h018, 32'h0000_000F);
        wr(12'h01C, 32'h0000_0801);
        rd(12'h018, d); chk("R8 normal mask", d, 32'hF);
        rd(12'h01C, d); chk("R8 normal ctrl", d, 32'h801);
        alt_layout = 1'b1;
        rd(12'h018, d); chk("R8 alt ctrl at 6", d, 32'h801);
        rd(12'h01C, d); chk("R8 alt mask at 7", d, 32'hF);
        wr(12'h018, 32'h0000_0001);
        chk("R8 alt write ctrl", 32'(display_on), 32'd0);
        alt_layout = 1'b0;
        rd(12'h01C, d); chk("R8 back ctrl", d, 32'h1);
        rd(12'h018, d); chk("R8 mask kept", d, 32'hF);

        // R9 / R10 interrupts
        wr(12'h018, 32'h0);
        wr(12'h028, 32'hF);
        pulse(4'b0101);
        rd(12'h020, d); chk("R9 raw set", d, 32'h5);
        rd(12'h024, d); chk("R9 masked zero", d, 32'h0);
        chk("R10 irq masked off", 32'(irq), 32'd0);
        wr(12'h018, 32'h4);
        chk("R10 irq lag", 32'(irq), 32'd0);
        @(negedge clk);
        chk("R10 irq rises", 32'(irq), 32'd1);
        rd(12'h024, d); chk("R9 masked", d, 32'h4);
        wr(12'h028, 32'h4);
        chk("R10 irq holds", 32'(irq), 32'd1);
        @(negedge clk);
        chk("R10 irq falls", 32'(irq), 32'd0);
        rd(12'h020, d); chk("R9 clear one bit", d, 32'h1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h028; bus_wdata = 32'h1; irq_src = 4'h1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; irq_src = '0;
        rd(12'h020, d); chk("R9 set wins", d, 32'h1);
        rd(12'h028, d); chk("R9 clear reads zero", d, 32'h0);
        wr(12'h028, 32'hF);
        rd(12'h020, d); chk("R9 clear all", d, 32'h0);
        wr(12'h018, 32'h2);
        pulse(4'b0010);
        chk("R10 lag after event", 32'(irq), 32'd0);
        @(negedge clk);
        chk("R10 irq after event", 32'(irq), 32'd1);
        wr(12'h028, 32'hF);
        wr(12'h020, 32'hF);
        chk("R9 ro write no err", 32'(bus_err), 32'd0);
        rd(12'h020, d); chk("R9 ro write ignored", d, 32'h0);
        wr(12'h02C, 32'h1234);
        rd(12'h010, d); chk("R9 current write ignored", d, 32'h8000_1000);

        // R12 identification
        for (int k = 0; k < 8; k++) begin
            logic [7:0] e;
            case (k)
                0: e = 8'h10; 1: e = 8'h11; 2: e = 8'h04; 3: e = 8'h00;
                4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
            endcase
            rd(12'hFE0 + 12'(k * 4), d);
            chk("R12 id byte", d, 32'(e));
        end

        // R13 unmapped accesses
        wr(12'h018, 32'h3);
        wr(12'h01C, 32'h801);
        rd(12'h034, d); chk("R13 read zero", d, 32'h0);
        chk("R13 err pulse", 32'(bus_err), 32'd1);
        @(negedge clk);
        chk("R13 err one cycle", 32'(bus_err), 32'd0);
        rd(12'h001, d); chk("R13 misaligned read zero", d, 32'h0);
        chk("R13 misaligned err", 32'(bus_err), 32'd1);
        rd(12'h200, d); chk("R13 mid window zero", d, 32'h0);
        wr(12'h3F0, 32'hFFFF_FFFF);
        chk("R13 write err", 32'(bus_err), 32'd1);
        wr(12'h019, 32'hFFFF_FFFF);
        chk("R13 misaligned write err", 32'(bus_err), 32'd1);
        rd(12'h018, d); chk("R13 mask untouched", d, 32'h3);
        rd(12'h01C, d); chk("R13 ctrl untouched", d, 32'h801);
        rd(12'h010, d); chk("R13 base untouched", d, 32'h8000_1000);
        chk("R13 mapped no err", 32'(bus_err), 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule